// File: doc/BRIEF.md
# Early-Terminating Iterative Multiply-Accumulate Unit

This block is a sequential multiplier that a processor pipeline starts with a one-cycle `start_i` pulse and that reports completion with a one-cycle `done_o` pulse. Each clock it recodes eight multiplier bits into four radix-4 Booth digits. It compresses the four digit addends with the fed-back partial sum and partial carry through a chain of four carry-save adders. The eight lowest bits of both vectors are then final, so they move into two result shift registers, and the upper bits move down by eight and return to the top of the chain.

Six operations are available: a 32-bit product, an unsigned 64-bit product and a signed 64-bit product, each with or without an accumulate term. The accumulate term is loaded into the partial-sum feedback register before the first compression cycle, so it costs no extra cycle. The multiplier is recoded on odd-aligned windows, which lets the first cycle reach one bit further. The correction term that this alignment needs, minus the multiplicand when multiplier bit 0 is set, enters through the spare partial-carry input on the first cycle only.

Compression stops as soon as the multiplier bits not yet consumed can only produce zero digits. A single 32-bit carry-propagate adder then adds the aligned sum and carry vectors, taking one pass for a 32-bit result and two passes, low half then high half, for a 64-bit result.

Top module: `mac_iter_mul`

## Requirements
- R1: While reset is applied and directly after it, `done_o` is 0, `result_o` is all zeros and `cycles_o` is 0.
- R2: `op_i` encodes bit 0 = 64-bit result, bit 1 = signed operands (used only with a 64-bit result), bit 2 = add `addend_i`. With bit 0 clear, `result_o[31:0]` is (mcand × mplier + addend[31:0]) mod 2^32 for either signedness, and `result_o[63:32]` is zero.
- R3: With bit 0 set and bit 1 clear, `result_o` is (unsigned mcand × unsigned mplier + addend) mod 2^64, where the addend term is zero when bit 2 is clear.
- R4: With bits 0 and 1 set, `result_o` is (signed mcand × signed mplier + addend) mod 2^64, where the addend term is zero when bit 2 is clear.
- R5: Enabling the accumulate never changes the number of compression cycles an operation takes.
- R6: `cycles_o` at `done_o` equals the smallest k in 1..4 for which the multiplier, extended to 33 bits and shifted arithmetically right by 8k, is all zeros, or all ones in a signed operation. A 32-bit result operation counts as signed for this rule and sign-extends its multiplier. During compression `cycles_o` rises by exactly one per clock.
- R7: A multiplier of 0x000000FF with a multiplicand of 1 completes after exactly one compression cycle.
- R8: Counting the edge that samples `start_i` as edge 0, `done_o` is high for exactly one cycle after edge n+1 for a 32-bit result and after edge n+2 for a 64-bit result, where n is the cycle count of R6.
- R9: `start_i` asserted while an operation is in progress is ignored: the running result is unchanged and no additional `done_o` follows.
- R10: `result_o` changes only in the cycle in which `done_o` is high and otherwise holds its last value.
- R11: No operation uses more than four compression cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins an operation when the unit is idle |
| op_i | input | 3 | Operation select: bit 0 wide result, bit 1 signed, bit 2 accumulate |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier; its value sets the cycle count |
| addend_i | input | 64 | Accumulate term; only bits 31:0 are used for a 32-bit result |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 64 | Product plus accumulate, held until the next completion |
| cycles_o | output | 3 | Compression cycles used by the current or most recent operation |

## Verification
On every cycle the assertions check the following: that the cycle counter advances by one per compression step, that the termination detector has fired by the fourth step, that the completion pulse lasts one cycle and reports a count between one and four, that the result register moves only together with that pulse, and that a 32-bit operation leaves the upper half clear. The arithmetic itself cannot be checked per cycle. The odd-aligned first window, the correction term, the inverted-addend carry injection and the carry across the two adder passes only show up in the bench's scenarios, which compare each result with an independently computed product plus accumulate. The same scenarios compare the cycle count with the termination rule applied to the multiplier, measure the latency, and pulse `start_i` in the middle of a run.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Sequencer states of the iterative multiplier.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMP   = 2'd1,
    ST_FIN_LO = 2'd2,
    ST_FIN_HI = 2'd3
  } mac_state_e;

  // Operation select as seen on the op_i port (bit 2 .. bit 0).
  typedef struct packed {
    logic acc;   // add the accumulate operand
    logic sgn;   // signed operands (wide results only)
    logic wide;  // 64-bit result
  } mac_op_t;

  // Decoded radix-4 digit: magnitude 0, 1 or 2 and a sign.
  typedef struct packed {
    logic zero;
    logic dbl;
    logic neg;
  } booth_sel_t;

  // Window bits are {upper, middle, lower}; digit = middle + lower - 2*upper.
  function automatic booth_sel_t booth_decode(input logic [2:0] win);
    booth_sel_t r;
    unique case (win)
      3'b001, 3'b010: r = '{zero: 1'b0, dbl: 1'b0, neg: 1'b0};
      3'b011:         r = '{zero: 1'b0, dbl: 1'b1, neg: 1'b0};
      3'b100:         r = '{zero: 1'b0, dbl: 1'b1, neg: 1'b1};
      3'b101, 3'b110: r = '{zero: 1'b0, dbl: 1'b0, neg: 1'b1};
      default:        r = '{zero: 1'b1, dbl: 1'b0, neg: 1'b0};
    endcase
    return r;
  endfunction

  // Three-input carry-save step: sum vector.
  function automatic logic [63:0] csa_sum(input logic [63:0] x, input logic [63:0] y,
                                          input logic [63:0] z);
    return x ^ y ^ z;
  endfunction

  // Three-input carry-save step: per-bit majority (carry before the shift).
  function automatic logic [63:0] csa_maj(input logic [63:0] x, input logic [63:0] y,
                                          input logic [63:0] z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/mac_csa_stage.sv
// One compression cycle: DIGITS Booth digits recoded from an odd-aligned
// window of the multiplier, each folded into the running sum/carry pair.
module mac_csa_stage
  import mac_pkg::*;
#(
  parameter int ACC_W  = 64,
  parameter int DIGITS = 4
) (
  input  logic [ACC_W-1:0]  a_ext,
  input  logic [ACC_W-1:0]  s_in,
  input  logic [ACC_W-1:0]  c_in,
  input  logic [2*DIGITS:0] win,
  output logic [ACC_W-1:0]  s_out,
  output logic [ACC_W-1:0]  c_out
);

  logic [ACC_W-1:0] s_ch [DIGITS+1];
  logic [ACC_W-1:0] c_ch [DIGITS+1];

  assign s_ch[0] = s_in;
  assign c_ch[0] = c_in;

  for (genvar j = 0; j < DIGITS; j++) begin : g_digit
    booth_sel_t       sel;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] pos;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] maj;

    assign sel    = booth_decode(win[2*j+2:2*j]);
    assign mag    = sel.zero ? '0 : (sel.dbl ? (a_ext << 1) : a_ext);
    // Digit j carries weight 2^(2j+1) inside the current frame.
    assign pos    = mag << (2*j + 1);
    // Negation: invert here, the +1 rides in the free carry LSB below.
    assign addend = sel.neg ? ~pos : pos;
    assign maj    = ACC_W'(csa_maj(64'(s_ch[j]), 64'(c_ch[j]), 64'(addend)));
    assign s_ch[j+1] = ACC_W'(csa_sum(64'(s_ch[j]), 64'(c_ch[j]), 64'(addend)));
    assign c_ch[j+1] = {maj[ACC_W-2:0], sel.neg};
  end

  assign s_out = s_ch[DIGITS];
  assign c_out = c_ch[DIGITS];

endmodule

// File: rtl/mac_half_add.sv
// The single carry-propagate adder, used once or twice per operation.
module mac_half_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  assign {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};

endmodule

// File: rtl/mac_iter_mul.sv
module mac_iter_mul
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIGITS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [2:0]                op_i,
  input  logic [DATA_W-1:0]         mcand_i,
  input  logic [DATA_W-1:0]         mplier_i,
  input  logic [2*DATA_W-1:0]       addend_i,
  output logic                      done_o,
  output logic [2*DATA_W-1:0]       result_o,
  output logic [$clog2(DATA_W/(2*DIGITS)+1)-1:0] cycles_o
);

  localparam int STEP    = 2 * DIGITS;            // multiplier bits per cycle
  localparam int ACC_W   = 2 * DATA_W;            // feedback / result width
  localparam int M_W     = DATA_W + 1;            // multiplier with extension bit
  localparam int MAX_CYC = DATA_W / STEP;         // worst-case compression cycles
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int CAT_W   = ACC_W + DATA_W;        // feedback plus retired bits
  localparam int SH_W    = $clog2(CAT_W) + 1;

  // True when the unconsumed multiplier bits can only yield zero digits.
  function automatic logic mplier_spent(input logic [M_W-1:0] rest, input logic sgn);
    return (rest == '0) || (sgn && (&rest));
  endfunction

  // ---------------------------------------------------------------- state
  mac_state_e       state_q;
  logic             wide_q;
  logic             sext_q;
  logic [ACC_W-1:0] a_q;
  logic [M_W-1:0]   m_q;
  logic [ACC_W-1:0] s_q;
  logic [ACC_W-1:0] c_q;
  logic [DATA_W-1:0] rs_q;
  logic [DATA_W-1:0] rc_q;
  logic             inc_q;
  logic             carry_q;
  logic [DATA_W-1:0] lo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ACC_W-1:0] res_q;
  logic             done_q;

  // ------------------------------------------------------ load operands
  mac_op_t          op_in;
  logic             sext_in;
  logic [ACC_W-1:0] a_ld;
  logic [M_W-1:0]   m_ld;
  logic [ACC_W-1:0] acc_ld;

  assign op_in   = mac_op_t'(op_i);
  // A 32-bit result is sign-agnostic, so it takes the signed path.
  assign sext_in = !op_in.wide || op_in.sgn;
  assign a_ld    = sext_in ? {{DATA_W{mcand_i[DATA_W-1]}}, mcand_i}
                           : {{DATA_W{1'b0}}, mcand_i};
  assign m_ld    = {sext_in & mplier_i[DATA_W-1], mplier_i};
  assign acc_ld  = !op_in.acc ? '0
                 : (op_in.wide ? addend_i : {{DATA_W{1'b0}}, addend_i[DATA_W-1:0]});

  // ---------------------------------------------------- named events
  logic accept_w;
  logic comp_w;
  logic term_w;
  logic wide_w;

  logic [M_W-1:0] m_next;
  assign m_next   = $signed(m_q) >>> STEP;
  assign accept_w = (state_q == ST_IDLE) && start_i;
  assign comp_w   = (state_q == ST_COMP);
  assign term_w   = mplier_spent(m_next, sext_q);
  assign wide_w   = wide_q;

  // ------------------------------------------------- compression chain
  logic [ACC_W-1:0] s_out;
  logic [ACC_W-1:0] c_out;

  mac_csa_stage #(
    .ACC_W (ACC_W),
    .DIGITS(DIGITS)
  ) u_stage (
    .a_ext(a_q),
    .s_in (s_q),
    .c_in (c_q),
    .win  (m_q[STEP:0]),
    .s_out(s_out),
    .c_out(c_out)
  );

  // ------------------------------------------- alignment and final add
  logic [SH_W-1:0]   sh_amt;
  logic [CAT_W-1:0]  cat_s;
  logic [CAT_W-1:0]  cat_c;
  logic [ACC_W-1:0]  fs;
  logic [ACC_W-1:0]  fc;
  logic              hi_pass;
  logic [DATA_W-1:0] add_x;
  logic [DATA_W-1:0] add_y;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;

  // Retired bits sit at the top of the shift registers; bring them down.
  assign sh_amt  = SH_W'(STEP * (MAX_CYC - int'(cnt_q)));
  assign cat_s   = {s_q, rs_q} >> sh_amt;
  assign cat_c   = {c_q, rc_q} >> sh_amt;
  assign fs      = cat_s[ACC_W-1:0];
  assign fc      = cat_c[ACC_W-1:0];
  assign hi_pass = (state_q == ST_FIN_HI);
  assign add_x   = hi_pass ? fs[ACC_W-1:DATA_W] : fs[DATA_W-1:0];
  assign add_y   = hi_pass ? fc[ACC_W-1:DATA_W] : fc[DATA_W-1:0];
  // The first-window correction's +1 enters as the low pass carry-in.
  assign add_cin = hi_pass ? carry_q : inc_q;

  mac_half_add #(
    .W(DATA_W)
  ) u_cpa (
    .x   (add_x),
    .y   (add_y),
    .cin (add_cin),
    .sum (add_sum),
    .cout(add_cout)
  );

  // ------------------------------------------------------- sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wide_q  <= 1'b0;
      sext_q  <= 1'b0;
      a_q     <= '0;
      m_q     <= '0;
      s_q     <= '0;
      c_q     <= '0;
      rs_q    <= '0;
      rc_q    <= '0;
      inc_q   <= 1'b0;
      carry_q <= 1'b0;
      lo_q    <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            wide_q  <= op_in.wide;
            sext_q  <= sext_in;
            a_q     <= a_ld;
            m_q     <= m_ld;
            s_q     <= acc_ld;
            // Spare input: -mcand when multiplier bit 0 is set (invert now).
            c_q     <= mplier_i[0] ? ~a_ld : '0;
            inc_q   <= mplier_i[0];
            rs_q    <= '0;
            rc_q    <= '0;
            cnt_q   <= '0;
            state_q <= ST_COMP;
          end
        end
        ST_COMP: begin
          s_q   <= $signed(s_out) >>> STEP;
          c_q   <= $signed(c_out) >>> STEP;
          rs_q  <= {s_out[STEP-1:0], rs_q[DATA_W-1:STEP]};
          rc_q  <= {c_out[STEP-1:0], rc_q[DATA_W-1:STEP]};
          m_q   <= m_next;
          cnt_q <= cnt_q + CNT_W'(1);
          if (term_w) state_q <= ST_FIN_LO;
        end
        ST_FIN_LO: begin
          lo_q    <= add_sum;
          carry_q <= add_cout;
          if (wide_q) begin
            state_q <= ST_FIN_HI;
          end else begin
            res_q   <= {{DATA_W{1'b0}}, add_sum};
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FIN_HI: begin
          res_q   <= {add_sum, lo_q};
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
  assign cycles_o = cnt_q;

endmodule

// File: rtl/mac_iter_mul_chk.sv
module mac_iter_mul_chk #(
  parameter int DATA_W = 32,
  parameter int DIGITS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                done_o,
  input logic [2*DATA_W-1:0] result_o,
  input logic [$clog2(DATA_W/(2*DIGITS)+1)-1:0] cycles_o,
  input logic                comp_w,
  input logic                term_w,
  input logic                wide_w
);

  localparam int MAX_CYC = DATA_W / (2 * DIGITS);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // R6: each compression step advances the visible count by one.
  p_cnt_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_w |=> (cycles_o == CNT_W'($past(cycles_o) + CNT_W'(1))));

  // R11: by the last permitted step the termination detector has fired.
  p_term_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_w && (cycles_o == CNT_W'(MAX_CYC - 1))) |-> term_w);

  // R11: a finished operation reports between one and MAX_CYC steps.
  p_cycles_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((cycles_o != '0) && (cycles_o <= CNT_W'(MAX_CYC))));

  // R8: completion is a single-cycle pulse.
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10: the result only moves together with the completion pulse.
  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R2: a 32-bit operation leaves the upper half clear.
  p_narrow_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_w) |-> (result_o[2*DATA_W-1:DATA_W] == '0));

endmodule

bind mac_iter_mul mac_iter_mul_chk #(
  .DATA_W(DATA_W),
  .DIGITS(DIGITS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_o  (done_o),
  .result_o(result_o),
  .cycles_o(cycles_o),
  .comp_w  (comp_w),
  .term_w  (term_w),
  .wide_w  (wide_w)
);

// File: tb/mac_iter_mul_tb_top.sv
`timescale 1ns/1ps
module mac_iter_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] mcand = '0;
  logic [31:0] mplier = '0;
  logic [63:0] addend = '0;
  logic        done;
  logic [63:0] result;
  logic [2:0]  cycles;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] res;
    int          cyc;
    logic [2:0]  op;
  } exp_t;

  exp_t exp_q[$];
  logic [63:0] last_res = '0;

  always #4 clk = ~clk;  // 125 MHz

  mac_iter_mul dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .op_i    (op),
    .mcand_i (mcand),
    .mplier_i(mplier),
    .addend_i(addend),
    .done_o  (done),
    .result_o(result),
    .cycles_o(cycles)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // Reference model: product plus accumulate, taken modulo the result width.
  function automatic logic [63:0] model_res(input logic [2:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic [63:0] acc);
    logic [31:0] lo;
    longint      sa;
    longint      sb;
    if (!o[0]) begin
      lo = a * b + (o[2] ? acc[31:0] : 32'd0);
      return {32'd0, lo};
    end else if (!o[1]) begin
      return ({32'd0, a} * {32'd0, b}) + (o[2] ? acc : 64'd0);
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb) + (o[2] ? acc : 64'd0);
    end
  endfunction

  // Reference count: first k where the remaining multiplier bits are idle.
  function automatic int model_cyc(input logic [2:0] o, input logic [31:0] b);
    bit     sx;
    longint mv;
    longint r;
    sx = !o[0] || o[1];
    mv = sx ? longint'($signed(b)) : longint'({32'd0, b});
    for (int k = 1; k <= 4; k++) begin
      r = mv >>> (8 * k);
      if (r == 0 || (sx && r == -1)) return k;
    end
    return 4;
  endfunction

  // Driver: pushes the expectation, starts, measures latency (R8).
  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [63:0] acc, input bit poke);
    exp_t e;
    int   lat;
    int   exp_lat;
    e.res = model_res(o, a, b, acc);
    e.cyc = model_cyc(o, b);
    e.op  = o;
    exp_q.push_back(e);
    exp_lat = e.cyc + (o[0] ? 2 : 1);
    @(negedge clk);
    op = o; mcand = a; mplier = b; addend = acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 1) begin
        // R9: a start during the run must be ignored.
        start = 1'b1; op = ~o; mcand = ~a; mplier = b ^ 32'h5A5A_0F0F; addend = ~acc;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk("R8 latency", 64'(lat), 64'(exp_lat));
    last_res = e.res;
    @(negedge clk);
    chk("R8 pulse", {63'd0, done}, 64'd0);
  endtask

  // Monitor: pops and compares on every completion.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done && !finished) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected done", 64'd1, 64'd0);
      end else begin
        e = exp_q.pop_front();
        chk(!e.op[0] ? "R2 result" : (e.op[1] ? "R4 result" : "R3 result"), result, e.res);
        chk(e.op[2] ? "R5 cycles" : "R6 cycles", 64'(cycles), 64'(e.cyc));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset is held and just after release.
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 result", result, 64'd0);
    chk("R1 cycles", 64'(cycles), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after release", {63'd0, done}, 64'd0);

    // R7: 0xFF multiplier, multiplicand 1 -> one compression cycle.
    run_op(3'b000, 32'h1, 32'h0000_00FF, 64'd0, 1'b0);
    chk("R7 one cycle", 64'(cycles), 64'd1);

    // R2: 32-bit results, negative multiplier terminates via all ones.
    run_op(3'b000, 32'd7, 32'hFFFF_FFFE, 64'd0, 1'b0);
    run_op(3'b010, 32'h8000_0001, 32'h1234_5678, 64'd0, 1'b0);
    run_op(3'b100, 32'hDEAD_BEEF, 32'h0000_0100, 64'hFFFF_FFFF_0000_0003, 1'b0);

    // R3: unsigned wide, worst case operands and a zero multiplier.
    run_op(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0);
    run_op(3'b001, 32'h1234_5678, 32'd0, 64'd0, 1'b0);
    run_op(3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);

    // R4: signed wide, extreme negative values with and without accumulate.
    run_op(3'b011, 32'h8000_0000, 32'h8000_0000, 64'd0, 1'b0);
    run_op(3'b011, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 64'd0, 1'b0);
    run_op(3'b111, 32'hFFFF_FF00, 32'h0000_7F01, 64'h8000_0000_0000_0001, 1'b0);

    // R5: same operands with and without accumulate give the same count.
    run_op(3'b011, 32'h0000_1234, 32'h00AB_CDEF, 64'd0, 1'b0);
    chk("R5 count no acc", 64'(cycles), 64'd3);
    run_op(3'b111, 32'h0000_1234, 32'h00AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0);
    chk("R5 count with acc", 64'(cycles), 64'd3);

    // R9: start pulsed mid-run on both result widths.
    run_op(3'b001, 32'hCAFE_F00D, 32'h8765_4321, 64'd0, 1'b1);
    run_op(3'b000, 32'h0000_0003, 32'h0000_0005, 64'd0, 1'b1);

    // R10: result held while idle.
    repeat (6) @(negedge clk);
    chk("R10 hold", result, last_res);
    chk("R9 no pending", 64'(exp_q.size()), 64'd0);

    // R2 R3 R4 R5 R6: mixed operand patterns over all flavours.
    for (int i = 0; i < 48; i++) begin
      logic [2:0]  o;
      logic [31:0] a;
      logic [31:0] b;
      logic [63:0] acc;
      o   = 3'($urandom_range(0, 7));
      a   = $urandom;
      b   = $urandom;
      acc = {$urandom, $urandom};
      case (i % 4)
        0: b = b >> 24;
        1: b = b >> 16;
        2: b = b | 32'hFFFF_0000;
        default: b = b;
      endcase
      run_op(o, a, b, acc, 1'b0);
    end

    repeat (4) @(negedge clk);
    chk("R6 queue drained", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    report();
    $finish;
  end

endmodule